// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This master-side block frees a two-wire bus that a target has left stuck with its data line held low. A protocol interruption, a power loss or a reset of the master can all leave the bus in that state. A one-cycle request starts a recovery run. The block toggles the clock line through its open-drain enable at a programmable low and high time. In the last cycle of each high phase it samples the data line.

As soon as a sample finds the data line released, clocking stops. The block then forms a START by pulling data low while the clock stays released. It follows this with a STOP, releases both lines and pulses `done_o`. If the data line is still low at the ninth sample, both lines are released and `fail_o` pulses instead.

All times are counted in cycles of `clk_i`. Enable outputs are active high: a 1 pulls the line low.

Top module: `bus_recover`

## Requirements
- R1: While `rst_ni` is low and after it is released, `scl_oe_o`, `sda_oe_o`, `done_o` and `fail_o` are 0.
- R2: A request accepted in idle starts clock pulses. In each pulse, `scl_oe_o` is 1 for LOW_CYC cycles and then 0 for HIGH_CYC cycles.
- R3: The data line is sampled in the last cycle of each high phase. `sda_oe_o` stays 0 throughout the clocking pulses.
- R4: At most 9 clock pulses are given. If the ninth sample still reads 0, the block returns to idle with both enables at 0, and `fail_o` is 1 for exactly that one cycle.
- R5: If a sample reads 1, the next cycle has `sda_oe_o`=1 with `scl_oe_o`=0 (START). This holds for HOLD_CYC cycles.
- R6: After the START, the block drives LOW_CYC cycles with both enables at 1, then HIGH_CYC cycles with only `sda_oe_o` at 1. It then releases both lines and returns to idle with `done_o` at 1 for one cycle.
- R7: While the clock line stays released, `sda_oe_o` changes only to form the START (rise) or the STOP (fall).
- R8: A request that arrives while a run is in progress has no effect on the run or on the outputs.
- R9: `done_o` and `fail_o` are never 1 together, and each lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a recovery run (accepted only in idle) |
| sda_i | input | 1 | Sensed data line level |
| scl_oe_o | output | 1 | Clock line pull-down enable |
| sda_oe_o | output | 1 | Data line pull-down enable |
| done_o | output | 1 | One-cycle pulse: bus freed, START/STOP issued |
| fail_o | output | 1 | One-cycle pulse: data still low after nine pulses |

## Verification
The outputs are a pure decode of the phase state, so a wrong state or a miscounted phase timer changes a line enable in the very cycle it happens. An off-by-one in the pulse counter shows up as a tenth low phase, or as an early failure, within one pulse period. A wrong sample point moves the START by a whole pulse. The per-cycle comparison against the bench model therefore catches all of these in the cycle they appear.

// File: rtl/rcv_pkg.sv
package rcv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_START,
    ST_PLOW,
    ST_PHIGH
  } rcv_state_e;
endpackage

// File: rtl/rcv_timer.sv
module rcv_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);

  a_r2_load_nonzero_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(load_i) && $past(load_val_i) != '0) |-> !expire_o);
endmodule

// File: rtl/rcv_pulse_cnt.sv
module rcv_pulse_cnt #(
  parameter int MAX_PULSES = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int PW = $clog2(MAX_PULSES + 1);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // last_o marks the sample that belongs to the final allowed pulse
  assign last_o = (cnt_q == PW'(MAX_PULSES - 1));

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < PW'(MAX_PULSES));
endmodule

// File: rtl/bus_recover.sv
module bus_recover #(
  parameter int LOW_CYC    = 150,
  parameter int HIGH_CYC   = 75,
  parameter int HOLD_CYC   = 75,
  parameter int MAX_PULSES = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic done_o,
  output logic fail_o
);
  import rcv_pkg::*;

  localparam int MAXC = (LOW_CYC > HIGH_CYC) ?
                        ((LOW_CYC > HOLD_CYC) ? LOW_CYC : HOLD_CYC) :
                        ((HIGH_CYC > HOLD_CYC) ? HIGH_CYC : HOLD_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LD_LOW  = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] LD_HIGH = CW'(HIGH_CYC - 1);
  localparam logic [CW-1:0] LD_HOLD = CW'(HOLD_CYC - 1);

  rcv_state_e st_q, st_d;
  logic          tmr_ld, tmr_exp;
  logic [CW-1:0] tmr_val;
  logic          pc_clr, pc_inc, pc_last;
  logic          done_d, fail_d, done_q, fail_q;

  rcv_timer #(.W(CW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_ld),
    .load_val_i(tmr_val), .expire_o(tmr_exp)
  );

  rcv_pulse_cnt #(.MAX_PULSES(MAX_PULSES)) u_pcnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(pc_clr),
    .inc_i(pc_inc), .last_o(pc_last)
  );

  always_comb begin
    st_d    = st_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    pc_clr  = 1'b0;
    pc_inc  = 1'b0;
    done_d  = 1'b0;
    fail_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        st_d = ST_LOW; tmr_ld = 1'b1; tmr_val = LD_LOW; pc_clr = 1'b1;
      end
      ST_LOW: if (tmr_exp) begin
        st_d = ST_HIGH; tmr_ld = 1'b1; tmr_val = LD_HIGH;
      end
      ST_HIGH: if (tmr_exp) begin
        if (sda_i) begin
          st_d = ST_START; tmr_ld = 1'b1; tmr_val = LD_HOLD;
        end else if (pc_last) begin
          st_d = ST_IDLE; fail_d = 1'b1;
        end else begin
          st_d = ST_LOW; tmr_ld = 1'b1; tmr_val = LD_LOW; pc_inc = 1'b1;
        end
      end
      ST_START: if (tmr_exp) begin
        st_d = ST_PLOW; tmr_ld = 1'b1; tmr_val = LD_LOW;
      end
      ST_PLOW: if (tmr_exp) begin
        st_d = ST_PHIGH; tmr_ld = 1'b1; tmr_val = LD_HIGH;
      end
      ST_PHIGH: if (tmr_exp) begin
        st_d = ST_IDLE; done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      fail_q <= fail_d;
    end
  end

  assign scl_oe_o = (st_q == ST_LOW) || (st_q == ST_PLOW);
  assign sda_oe_o = (st_q == ST_START) || (st_q == ST_PLOW) || (st_q == ST_PHIGH);
  assign done_o   = done_q;
  assign fail_o   = fail_q;

  a_r7_sda_quiet_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_o && !$past(scl_oe_o) && (sda_oe_o != $past(sda_oe_o))) |->
    ((sda_oe_o && st_q == ST_START) || (!sda_oe_o && st_q == ST_IDLE)));

  a_r2_phase_on_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_LOW && st_q == ST_HIGH) |-> $past(tmr_exp));

  a_r4_fail_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (!scl_oe_o && !sda_oe_o));

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_fail_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !fail_o);

  a_r5_start_after_high_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> ($past(st_q) == ST_HIGH && $past(sda_i)));
endmodule

// File: tb/sim_bus_recover.sv
`timescale 1ns/1ps
module sim_bus_recover;
  localparam int TL = 6, TH = 4, THD = 3, NMAX = 9;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, sda_i = 1'b1;
  logic scl_oe, sda_oe, done, fail;
  int checks = 0, failures = 0, cyc = 0;

  bus_recover #(.LOW_CYC(TL), .HIGH_CYC(TH), .HOLD_CYC(THD), .MAX_PULSES(NMAX)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .sda_i(sda_i),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .done_o(done), .fail_o(fail)
  );

  always #4 clk = ~clk;

  // reference model: 0 idle,1 clk low,2 clk high,3 start,4 stop low,5 stop high
  int m_ph = 0, m_left = 0, m_pulse = 0;
  bit m_done = 0, m_fail = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_pulse = 0; m_done = 0; m_fail = 0;
    end else begin
      m_done = 0; m_fail = 0;
      if (m_ph == 0) begin
        if (req) begin m_ph = 1; m_left = TL; m_pulse = 1; end
      end else begin
        m_left--;
        if (m_left == 0) begin
          case (m_ph)
            1: begin m_ph = 2; m_left = TH; end
            2: if (sda_i) begin m_ph = 3; m_left = THD; end
               else if (m_pulse == NMAX) begin m_ph = 0; m_fail = 1; end
               else begin m_ph = 1; m_left = TL; m_pulse++; end
            3: begin m_ph = 4; m_left = TL; end
            4: begin m_ph = 5; m_left = TH; end
            default: begin m_ph = 0; m_done = 1; end
          endcase
        end
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", tag, cyc, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // stuck target: holds data low until it has seen hold_n clock falls
  int hold_n = 0, falls = 0, n_done = 0, n_fail = 0;
  bit hold_en = 0, prev_scl = 1;
  bit prev_scl_rel = 1, prev_sda_oe = 0;
  always @(negedge clk) begin
    cyc++;
    if (!(!scl_oe) && prev_scl) falls++;
    prev_scl = !scl_oe;
    sda_i = !(sda_oe || (hold_en && falls < hold_n));
    if (rst_n) begin
      chk("R2 scl_oe", scl_oe, (m_ph == 1 || m_ph == 4));
      chk("R3 R5 R6 sda_oe", sda_oe, (m_ph == 3 || m_ph == 4 || m_ph == 5));
      chk("R6 done", done, m_done);
      chk("R4 fail", fail, m_fail);
      checks++;
      if (done && fail) begin
        failures++;
        $display("FAIL R9 done and fail together: actual=1 expected=0");
      end
      checks++;
      if (!scl_oe && prev_scl_rel && sda_oe != prev_sda_oe &&
          !((sda_oe && m_ph == 3) || (!sda_oe && m_ph == 0))) begin
        failures++;
        $display("FAIL R7 sda_oe moved with clock released: actual=%0b expected=%0b",
                 sda_oe, prev_sda_oe);
      end
      if (done) n_done++;
      if (fail) n_fail++;
    end
    prev_scl_rel = !scl_oe;
    prev_sda_oe  = sda_oe;
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    finish_run();
  end

  task automatic run(input int n, input bit extra_req);
    int exp_pulses;
    bit ok;
    @(negedge clk);
    hold_n = n; hold_en = 1; falls = 0; n_done = 0; n_fail = 0;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 15; i++) @(negedge clk);
    if (extra_req) begin req = 1'b1; @(negedge clk); req = 1'b0; end
    while (m_ph != 0) @(negedge clk);
    for (int i = 0; i < 5; i++) @(negedge clk);
    ok = (n <= NMAX);
    exp_pulses = ok ? ((n < 1) ? 1 : n) : NMAX;
    chk_int("R4 clock falls in run", falls, exp_pulses + (ok ? 1 : 0));
    chk_int(extra_req ? "R8 done count" : "R6 done count", n_done, ok ? 1 : 0);
    chk_int("R4 fail count", n_fail, ok ? 0 : 1);
    hold_en = 0;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 scl_oe in reset", scl_oe, 1'b0);
      chk("R1 sda_oe in reset", sda_oe, 1'b0);
      chk("R1 done in reset", done, 1'b0);
      chk("R1 fail in reset", fail, 1'b0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk("R1 idle after reset", scl_oe | sda_oe, 1'b0);
    run(0, 0);
    run(3, 0);
    run(3, 1);
    run(9, 0);
    run(10, 0);
    run(20, 1);
    run(1, 0);
    finish_run();
  end
endmodule